// File: doc/BRIEF.md
# Cache Line Alert Tracker

This block adds a single alert mark to each line of a small set-associative cache. Software marks the lines it cares about. When a marked line leaves the cache, the block raises an alert toward the processor. The alert is redirected to a registered handler address, and the interrupted PC is kept for the return. Software issues its requests on a command port. The requests are: mark a line, unmark a line, unmark every line, load the handler address, clear the handler address, and re-enable alerts. The cache reports lines that leave it on an eviction port, tagged with the cause: a write by another agent, or a replacement.

Each alert is classified by cause. After an alert is delivered, further alerts are masked until software re-enables them. A marked-line eviction that arrives while alerts are masked is held as pending. If a second such eviction arrives before the first has been delivered, the two are reported together as one lost-alert event. While no handler is registered (the handler address is zero), evictions raise nothing.

Commands name a line by the set index taken from address bits above the 64-byte line offset, plus the way in which the cache lookup found the line. The eviction port names the set and way directly.

Top module: `alert_track_unit`

## Requirements
- R1: A mark command (cmd_op=1) sets the mark of line (set = cmd_addr[8:6], way = cmd_way). In the next cycle mark_rsp_valid is 1, and mark_rsp_prev is 1 only if that line was already marked.
- R2: An unmark command (cmd_op=2) clears the mark of the addressed line only. Other lines of the same set keep their marks.
- R3: An unmark-all command (cmd_op=3) clears the mark of every line in one cycle.
- R4: A clear-handler command (cmd_op=5) sets alert_target to zero, clears every mark and drops any pending event. A set-handler command (cmd_op=4) loads cmd_addr into alert_target.
- R5: An eviction of a marked line, with a non-zero handler and alert_en high, produces a one-cycle alert_fire pulse two cycles after the eviction cycle. The eviction also clears the mark of that line. An eviction of an unmarked line raises nothing.
- R6: alert_type takes the value 1 for a remote-write cause (evict_cause=0) and 2 for a replacement cause (evict_cause=1). It takes the value 3 (lost) when a second marked eviction arrived before the first one was delivered.
- R7: Delivery of an alert clears alert_en. An enable command (cmd_op=6) sets alert_en again. No alert is delivered while alert_en is low.
- R8: On delivery, alert_old_pc holds the cur_pc value of the cycle in which the alert was taken, and alert_target holds the handler address.
- R9: The low 6 address bits are ignored. Two addresses inside the same 64-byte line select the same line.
- R10: A marked eviction that arrives while alert_en is low is held pending. It is delivered in the cycle after an enable command.
- R11: While alert_target is zero, evictions of marked lines raise no alert.
- R12: When an eviction and a mark command hit the same line in the same cycle, the eviction is applied first. The mark then reports mark_rsp_prev = 0, and the eviction still raises its alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 1 mark, 2 unmark, 3 unmark all, 4 set handler, 5 clear handler, 6 enable |
| cmd_addr | input | ADDR_W | Line address for mark/unmark; handler address for set handler |
| cmd_way | input | WAY_W | Way in which the cache holds the addressed line |
| mark_rsp_valid | output | 1 | Mark response present |
| mark_rsp_prev | output | 1 | The line was already marked before the mark |
| evict_valid | input | 1 | A line leaves the cache this cycle |
| evict_set | input | SET_W | Set of the departing line |
| evict_way | input | WAY_W | Way of the departing line |
| evict_cause | input | 1 | 0 remote write, 1 capacity or conflict replacement |
| cur_pc | input | ADDR_W | Current processor PC |
| alert_fire | output | 1 | One-cycle alert delivery pulse |
| alert_target | output | ADDR_W | Handler address, redirect target |
| alert_old_pc | output | ADDR_W | PC saved at the last delivery |
| alert_type | output | 2 | Cause of the last delivered alert |
| alert_en | output | 1 | Alerts are enabled |

## Verification
The assertions watch, on every cycle, the following properties:
- Every mark is answered in the next cycle and leaves its line marked.
- An eviction that coincides with a mark of the same line makes the mark report "not previously set".
- Unmark-all leaves no line marked.
- A delivery occurs only with alerts enabled, clears the enable bit, lasts one cycle, and captures the previous cycle's PC.
- Nothing fires while the handler is zero.

Only the directed scenarios can show the following:
- The cause encoding, including the folding of two undelivered events into a lost alert.
- Pending events surviving a masked period and being delivered after re-enable.
- Unmark sparing the neighbouring way.
- Clear-handler wiping the marks.

// File: rtl/alert_track_pkg.sv
package alert_track_pkg;

    typedef enum logic [2:0] {
        OP_NOP           = 3'd0,
        OP_MARK          = 3'd1,
        OP_UNMARK        = 3'd2,
        OP_UNMARK_ALL    = 3'd3,
        OP_SET_HANDLER   = 3'd4,
        OP_CLEAR_HANDLER = 3'd5,
        OP_ENABLE        = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        AT_NONE   = 2'd0,
        AT_REMOTE = 2'd1,
        AT_EVICT  = 2'd2,
        AT_LOST   = 2'd3
    } atype_e;

endpackage

// File: rtl/alert_mark_array.sv
module alert_mark_array #(
    parameter int SETS = 8,
    parameter int WAYS = 2,
    localparam int LINES = SETS * WAYS,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             op_mark,
    input  logic             op_unmark,
    input  logic             op_clear_all,
    input  logic [IDX_W-1:0] op_idx,
    output logic             evict_hit,
    output logic             rsp_valid,
    output logic             rsp_prev
);

    typedef struct packed {
        logic [LINES-1:0] bits;
        logic             rsp_valid;
        logic             rsp_prev;
    } mark_st_t;

    mark_st_t st_q, st_d;
    logic [LINES-1:0] evict_mask, op_mask;

    // One-hot line selects, one per line
    for (genvar g = 0; g < LINES; g++) begin : g_sel
        assign evict_mask[g] = evict_valid && (evict_idx == IDX_W'(g));
        assign op_mask[g]    = (op_idx == IDX_W'(g));
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_prev  = 1'b0;
        evict_hit      = |(st_q.bits & evict_mask);
        // the eviction is applied before any command on the same line
        st_d.bits      = st_d.bits & ~evict_mask;
        if (op_clear_all) st_d.bits = '0;
        if (op_unmark)    st_d.bits = st_d.bits & ~op_mask;
        if (op_mark) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_prev  = |(st_d.bits & op_mask);
            st_d.bits      = st_d.bits | op_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_prev  = st_q.rsp_prev;

    // R1
    mark_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_mark |=> (rsp_valid && st_q.bits[$past(op_idx)]));

    // R12
    evict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mark && evict_valid && op_idx == evict_idx) |=> !rsp_prev);

    // R3
    flash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_clear_all && !op_mark) |=> (st_q.bits == '0));

endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
    import alert_track_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_handler,
    input  logic              clear_handler,
    input  logic              enable,
    input  logic [ADDR_W-1:0] handler_addr,
    input  logic              evict_hit,
    input  logic              evict_cause,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              alert_fire,
    output logic [ADDR_W-1:0] handler,
    output logic [ADDR_W-1:0] old_pc,
    output logic [1:0]        alert_type,
    output logic              alert_en
);

    typedef struct packed {
        logic [ADDR_W-1:0] handler;
        logic [ADDR_W-1:0] old_pc;
        logic              en;
        logic              pend;
        atype_e            ptype;
        atype_e            atype;
        logic              fire;
    } ctrl_st_t;

    ctrl_st_t st_q, st_d;
    logic armed, deliver;

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        armed     = (st_q.handler != '0);
        deliver   = st_q.pend && st_q.en && armed;

        if (deliver) begin
            st_d.fire   = 1'b1;
            st_d.en     = 1'b0;
            st_d.old_pc = cur_pc;
            st_d.atype  = st_q.ptype;
            st_d.pend   = 1'b0;
            st_d.ptype  = AT_NONE;
        end
        if (evict_hit && armed) begin
            if (st_q.pend && !deliver) st_d.ptype = AT_LOST;
            else st_d.ptype = evict_cause ? AT_EVICT : AT_REMOTE;
            st_d.pend = 1'b1;
        end
        // a delivery in the same cycle masks again
        if (enable && !deliver) st_d.en = 1'b1;
        if (set_handler) st_d.handler = handler_addr;
        if (clear_handler) begin
            st_d.handler = '0;
            st_d.pend    = 1'b0;
            st_d.ptype   = AT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alert_fire = st_q.fire;
    assign handler    = st_q.handler;
    assign old_pc     = st_q.old_pc;
    assign alert_type = st_q.atype;
    assign alert_en   = st_q.en;

    // R7
    fire_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_fire |-> (!alert_en && $past(alert_en)));

    // R7
    fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_fire |=> !alert_fire);

    // R8
    old_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_fire |-> (old_pc == $past(cur_pc)));

    // R11
    no_handler_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (handler == '0) |=> !alert_fire);

endmodule

// File: rtl/alert_track_unit.sv
module alert_track_unit
    import alert_track_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 8,
    parameter int WAYS       = 2,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WAY_W-1:0]  cmd_way,
    output logic              mark_rsp_valid,
    output logic              mark_rsp_prev,
    input  logic              evict_valid,
    input  logic [SET_W-1:0]  evict_set,
    input  logic [WAY_W-1:0]  evict_way,
    input  logic              evict_cause,
    input  logic [ADDR_W-1:0] cur_pc,
    output logic              alert_fire,
    output logic [ADDR_W-1:0] alert_target,
    output logic [ADDR_W-1:0] alert_old_pc,
    output logic [1:0]        alert_type,
    output logic              alert_en
);

    localparam int LINES = SETS * WAYS;
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    op_e              op;
    logic [SET_W-1:0] cmd_set;
    logic [IDX_W-1:0] op_idx, evict_idx;
    logic             evict_hit;

    assign op        = cmd_valid ? op_e'(cmd_op) : OP_NOP;
    assign cmd_set   = cmd_addr[OFF_W +: SET_W];
    assign op_idx    = IDX_W'(int'(cmd_set) * WAYS + int'(cmd_way));
    assign evict_idx = IDX_W'(int'(evict_set) * WAYS + int'(evict_way));

    alert_mark_array #(.SETS(SETS), .WAYS(WAYS)) u_marks (
        .clk          (clk),
        .rst_n        (rst_n),
        .evict_valid  (evict_valid),
        .evict_idx    (evict_idx),
        .op_mark      (op == OP_MARK),
        .op_unmark    (op == OP_UNMARK),
        .op_clear_all (op == OP_UNMARK_ALL || op == OP_CLEAR_HANDLER),
        .op_idx       (op_idx),
        .evict_hit    (evict_hit),
        .rsp_valid    (mark_rsp_valid),
        .rsp_prev     (mark_rsp_prev)
    );

    alert_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_handler   (op == OP_SET_HANDLER),
        .clear_handler (op == OP_CLEAR_HANDLER),
        .enable        (op == OP_ENABLE),
        .handler_addr  (cmd_addr),
        .evict_hit     (evict_hit),
        .evict_cause   (evict_cause),
        .cur_pc        (cur_pc),
        .alert_fire    (alert_fire),
        .handler       (alert_target),
        .old_pc        (alert_old_pc),
        .alert_type    (alert_type),
        .alert_en      (alert_en)
    );

endmodule

// File: tb/tb_alert_track_unit.sv
module tb_alert_track_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_addr;
    logic [0:0]  cmd_way;
    logic        mark_rsp_valid, mark_rsp_prev;
    logic        evict_valid;
    logic [2:0]  evict_set;
    logic [0:0]  evict_way;
    logic        evict_cause;
    logic [31:0] cur_pc;
    logic        alert_fire;
    logic [31:0] alert_target, alert_old_pc;
    logic [1:0]  alert_type;
    logic        alert_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alert_track_unit dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] la(input int set, input int off);
        return (32'(set) << 6) | 32'(off);
    endfunction

    task automatic cmd(input logic [2:0] op, input logic [31:0] addr, input logic w);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_way = w;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic mark(input int set, input logic w, input logic exp_prev, input string req);
        cmd(3'd1, la(set, 0), w);
        chk(req, {mark_rsp_valid, mark_rsp_prev}, {1'b1, exp_prev});
    endtask

    task automatic evict(input int set, input logic w, input logic cause);
        evict_valid = 1'b1; evict_set = 3'(set); evict_way = w; evict_cause = cause;
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, alert_fire, 1'b0);
        end
    endtask

    task automatic t_reset();
        chk("R7 reset en", alert_en, 1'b0);
        chk("R4 reset target", alert_target, 32'd0);
        chk("R5 reset fire", alert_fire, 1'b0);
        chk("R6 reset type", alert_type, 2'd0);
        chk("R1 reset rsp", mark_rsp_valid, 1'b0);
    endtask

    task automatic t_mark();
        cmd(3'd4, 32'h1000, 1'b0);
        chk("R4 set handler", alert_target, 32'h1000);
        cmd(3'd6, 32'd0, 1'b0);
        chk("R7 enable", alert_en, 1'b1);
        mark(2, 1'b1, 1'b0, "R1 first mark");
        mark(2, 1'b1, 1'b1, "R1 second mark");
        cmd(3'd1, la(5, 6'h3F), 1'b0);
        chk("R9 mark high offset", mark_rsp_prev, 1'b0);
        mark(5, 1'b0, 1'b1, "R9 same line offset zero");
    endtask

    task automatic t_unmark();
        mark(2, 1'b0, 1'b0, "R1 way0 mark");
        cmd(3'd2, la(2, 4), 1'b0);
        mark(2, 1'b0, 1'b0, "R2 unmarked line");
        mark(2, 1'b1, 1'b1, "R2 neighbour kept");
    endtask

    task automatic t_unmark_all();
        cmd(3'd3, 32'd0, 1'b0);
        mark(2, 1'b1, 1'b0, "R3 set2 way1 cleared");
        mark(5, 1'b0, 1'b0, "R3 set5 way0 cleared");
        cmd(3'd3, 32'd0, 1'b0);
    endtask

    task automatic t_remote();
        mark(3, 1'b0, 1'b0, "R1 mark set3");
        cur_pc = 32'h4440;
        evict(3, 1'b0, 1'b0);
        chk("R5 no fire yet", alert_fire, 1'b0);
        @(negedge clk);
        chk("R5 fire", alert_fire, 1'b1);
        chk("R6 remote type", alert_type, 2'd1);
        chk("R7 masked after fire", alert_en, 1'b0);
        chk("R8 old pc", alert_old_pc, 32'h4440);
        chk("R8 target", alert_target, 32'h1000);
        @(negedge clk);
        chk("R5 single pulse", alert_fire, 1'b0);
        mark(3, 1'b0, 1'b0, "R5 eviction cleared mark");
        cmd(3'd6, 32'd0, 1'b0);
        chk("R7 re-enable", alert_en, 1'b1);
    endtask

    task automatic t_capacity();
        mark(4, 1'b1, 1'b0, "R1 mark set4");
        cur_pc = 32'h5550;
        evict(4, 1'b1, 1'b1);
        @(negedge clk);
        chk("R5 capacity fire", alert_fire, 1'b1);
        chk("R6 capacity type", alert_type, 2'd2);
        chk("R8 old pc capacity", alert_old_pc, 32'h5550);
        cmd(3'd6, 32'd0, 1'b0);
    endtask

    task automatic t_unmarked();
        evict(5, 1'b0, 1'b0);
        quiet(3, "R5 unmarked eviction");
        chk("R6 type kept", alert_type, 2'd2);
    endtask

    task automatic t_pending();
        evict(3, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5 fire to mask", alert_fire, 1'b1);
        mark(6, 1'b0, 1'b0, "R1 mark set6");
        evict(6, 1'b0, 1'b0);
        quiet(3, "R10 held while masked");
        cmd(3'd6, 32'd0, 1'b0);
        chk("R10 not yet", alert_fire, 1'b0);
        @(negedge clk);
        chk("R10 delivered", alert_fire, 1'b1);
        chk("R10 pending type", alert_type, 2'd1);
    endtask

    task automatic t_lost();
        mark(1, 1'b0, 1'b0, "R1 mark set1 way0");
        mark(1, 1'b1, 1'b0, "R1 mark set1 way1");
        evict(1, 1'b0, 1'b1);
        evict(1, 1'b1, 1'b0);
        quiet(2, "R10 masked");
        cmd(3'd6, 32'd0, 1'b0);
        @(negedge clk);
        chk("R6 lost fire", alert_fire, 1'b1);
        chk("R6 lost type", alert_type, 2'd3);
    endtask

    task automatic t_clear_handler();
        mark(2, 1'b0, 1'b0, "R1 mark set2 way0");
        cmd(3'd5, 32'd0, 1'b0);
        chk("R4 target zero", alert_target, 32'd0);
        mark(2, 1'b0, 1'b0, "R4 marks wiped");
        cmd(3'd6, 32'd0, 1'b0);
        evict(2, 1'b0, 1'b0);
        quiet(3, "R11 no handler");
        chk("R11 enable kept", alert_en, 1'b1);
    endtask

    task automatic t_same_cycle();
        cmd(3'd4, 32'h2000, 1'b0);
        mark(7, 1'b1, 1'b0, "R1 mark set7");
        evict_valid = 1'b1; evict_set = 3'd7; evict_way = 1'b1; evict_cause = 1'b0;
        cmd(3'd1, la(7, 0), 1'b1);
        evict_valid = 1'b0;
        chk("R12 mark after evict", {mark_rsp_valid, mark_rsp_prev}, 2'b10);
        @(negedge clk);
        chk("R12 eviction alert", alert_fire, 1'b1);
        chk("R8 new target", alert_target, 32'h2000);
        mark(7, 1'b1, 1'b1, "R12 mark stands");
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = '0; cmd_way = '0;
        evict_valid = 1'b0; evict_set = '0; evict_way = '0; evict_cause = 1'b0;
        cur_pc = 32'h100;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mark();
        t_unmark();
        t_unmark_all();
        t_remote();
        t_capacity();
        t_unmarked();
        t_pending();
        t_lost();
        t_clear_handler();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule